// File: doc/BRIEF.md
# RTC Periodic Interrupt Generator

This block raises a periodic event for a real-time-clock peripheral. It counts strobes of a 32768 Hz timebase. Each time a programmed number of strobes has passed, it sets a sticky periodic flag. If the interrupt enable is on, it also sets the interrupt-request flag that drives the interrupt line. A 4-bit rate code picks the period as a power of two of the timebase. A 3-bit divider-control field lets the prescaler run, freezes it, or holds it cleared.

Software reads the shared flag register to find out why the line went high. The `flagRead` pulse marks that read, and it clears both flags and drops the line. Writing a different rate code restarts the phase, so the first event after the change comes one full new period later.

Top module: `piGen`

## Requirements
- R1: For a rate code from 3 to 15, the period is 2^(code-1) timebase strobes. Events keep repeating at that period while the code stays the same.
- R2: Rate code 1 gives a period of 128 strobes, and rate code 2 gives 256 strobes.
- R3: `pfFlag` is set on every period expiry, whatever the value of `irqEnable`. If `irqEnable` is low when a period expires, `irqReq` does not rise.
- R4: When a period expires with `irqEnable` high, `irqReq` (the interrupt-request flag) is set in the same cycle as `pfFlag`. `irqReq` is never high while `pfFlag` is low.
- R5: A `divCtl` value of 3'b110 or 3'b111 clears the period counter and blocks all expiries. When `divCtl` returns to 3'b010 or below, counting restarts from zero, so a full period must pass before the next event.
- R6: A `divCtl` value of 3'b011, 3'b100 or 3'b101 freezes the period counter and keeps its count. Strobes that arrive meanwhile are ignored, and counting resumes from the held value.
- R7: Rate code 0 produces no expiries and keeps the period counter at zero.
- R8: After `rateSel` changes, the next running timebase strobe resets the counter to zero and is not counted. The first event at the new rate then comes one full new period of strobes later.
- R9: A one-cycle `flagRead` pulse clears `pfFlag` and `irqReq`. If an expiry happens in the same cycle, the expiry wins and the flags are set.
- R10: After reset, `pfFlag` and `irqReq` are low and the period counter is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickEn | input | 1 | One-cycle strobe at the 32768 Hz timebase rate |
| rateSel | input | 4 | Periodic rate code; 0 disables |
| divCtl | input | 3 | Divider control: 0–2 run, 3–5 freeze, 6–7 hold cleared |
| irqEnable | input | 1 | Periodic interrupt enable |
| flagRead | input | 1 | Pulse marking a read of the flag register; clears the flags |
| pfFlag | output | 1 | Sticky periodic flag |
| irqReq | output | 1 | Interrupt-request flag, which also drives the interrupt line |

## Verification
A wrong count or a missed restart shows up as `pfFlag` rising one or more strobes too early or too late. The bench catches this at the single strobe where the first event is due, by checking one strobe before and then exactly at the expected strobe. A counter that was not cleared or not frozen in the divider modes also shifts the next event, so that error appears within one period after release. A flag-clear fault shows up one cycle after the read pulse.

// File: rtl/piGenPkg.sv
package piGenPkg;
  localparam int RATE_W = 4;
  localparam int DIV_W  = 3;
  localparam int CNT_W  = (1 << RATE_W) - 2;

  typedef struct packed {
    logic             clear;
    logic             step;
    logic [CNT_W-1:0] lastCount;
  } piStrobe_t;
endpackage

// File: rtl/piCtrl.sv
module piCtrl
  import piGenPkg::*;
#(
  parameter int LOW1_LOG = 7,
  parameter int LOW2_LOG = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic [RATE_W-1:0] rateSel,
  input  logic [DIV_W-1:0]  divCtl,
  output piStrobe_t         strb
);
  localparam logic [DIV_W-1:0] RUN_MAX = DIV_W'(2);

  logic [RATE_W-1:0] rateQ;
  logic              pendingQ;
  logic              divHold, divRun, rateZero, rateChange, restartNow, restartTick;
  logic [CNT_W:0]    spanWide;

  assign divHold     = (divCtl[DIV_W-1 -: 2] == 2'b11);
  assign divRun      = (divCtl <= RUN_MAX);
  assign rateZero    = (rateSel == '0);
  assign rateChange  = (rateSel != rateQ);
  assign restartNow  = rateChange | pendingQ;
  assign restartTick = tickEn & divRun & restartNow;

  // rate decode: terminal count of the period counter
  always_comb begin
    spanWide = '0;
    case (rateSel)
      RATE_W'(0): spanWide = '0;
      RATE_W'(1): spanWide = (CNT_W+1)'(1) << LOW1_LOG;
      RATE_W'(2): spanWide = (CNT_W+1)'(1) << LOW2_LOG;
      default:    spanWide = (CNT_W+1)'(1) << (rateSel - RATE_W'(1));
    endcase
  end

  always_comb begin
    strb.lastCount = rateZero ? '0 : CNT_W'(spanWide - (CNT_W+1)'(1));
    strb.clear     = divHold | rateZero | restartTick;
    strb.step      = tickEn & divRun & ~rateZero & ~restartNow;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rateQ    <= '0;
      pendingQ <= 1'b0;
    end else begin
      rateQ <= rateSel;
      if (restartTick)     pendingQ <= 1'b0;
      else if (rateChange) pendingQ <= 1'b1;
    end
  end

  // a restart owed to a rate change survives until a strobe consumes it
  assert_pending_kept_R8: assert property (@(posedge clk) disable iff (!rstN)
    (pendingQ && !tickEn) |=> pendingQ);

  // no counting in a cleared or frozen divider mode
  assert_no_step_held_R6: assert property (@(posedge clk) disable iff (!rstN)
    (divCtl > RUN_MAX) |-> !strb.step);
endmodule

// File: rtl/piDatapath.sv
module piDatapath
  import piGenPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  piStrobe_t strb,
  input  logic      irqEnable,
  input  logic      flagRead,
  output logic      pfFlag,
  output logic      irqReq
);
  logic [CNT_W-1:0] count;
  logic             expire, pfQ, irqfQ;

  assign expire = strb.step && (count == strb.lastCount);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count <= '0;
    end else if (strb.clear) begin
      count <= '0;
    end else if (strb.step) begin
      count <= expire ? '0 : count + CNT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pfQ   <= 1'b0;
      irqfQ <= 1'b0;
    end else begin
      if (expire)        pfQ <= 1'b1;
      else if (flagRead) pfQ <= 1'b0;
      if (expire && irqEnable) irqfQ <= 1'b1;
      else if (flagRead)       irqfQ <= 1'b0;
    end
  end

  assign pfFlag = pfQ;
  assign irqReq = irqfQ;

  assert_pf_source_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pfQ) |-> $past(expire));

  assert_disabled_quiet_R3: assert property (@(posedge clk) disable iff (!rstN)
    (expire && !irqEnable && !irqfQ) |=> !irqfQ);

  assert_irqf_with_pf_R4: assert property (@(posedge clk) disable iff (!rstN)
    irqfQ |-> pfQ);

  assert_clear_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    strb.clear |=> (count == '0));

  assert_read_clears_R9: assert property (@(posedge clk) disable iff (!rstN)
    (flagRead && !expire) |=> (!pfQ && !irqfQ));
endmodule

// File: rtl/piGen.sv
module piGen
  import piGenPkg::*;
#(
  parameter int LOW1_LOG = 7,
  parameter int LOW2_LOG = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              tickEn,
  input  logic [RATE_W-1:0] rateSel,
  input  logic [DIV_W-1:0]  divCtl,
  input  logic              irqEnable,
  input  logic              flagRead,
  output logic              pfFlag,
  output logic              irqReq
);
  piStrobe_t strb;

  piCtrl #(.LOW1_LOG(LOW1_LOG), .LOW2_LOG(LOW2_LOG)) uCtrl (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .rateSel(rateSel),
    .divCtl(divCtl), .strb(strb)
  );

  piDatapath uData (
    .clk(clk), .rstN(rstN), .strb(strb), .irqEnable(irqEnable),
    .flagRead(flagRead), .pfFlag(pfFlag), .irqReq(irqReq)
  );
endmodule

// File: tb/sim_piGen.sv
`timescale 1ns/1ps
module sim_piGen;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       tickEn = 1'b0;
  logic [3:0] rateSel = 4'd0;
  logic [2:0] divCtl = 3'b010;
  logic       irqEnable = 1'b0;
  logic       flagRead = 1'b0;
  logic       pfFlag, irqReq;
  int nVec = 0;
  int nBad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  piGen u0 (
    .clk(clk), .rstN(rstN), .tickEn(tickEn), .rateSel(rateSel),
    .divCtl(divCtl), .irqEnable(irqEnable), .flagRead(flagRead),
    .pfFlag(pfFlag), .irqReq(irqReq)
  );

  task automatic check(string tag, logic act, logic exp);
    nVec++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: got %b expected %b", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk) tickEn = 1'b1;
      @(negedge clk) tickEn = 1'b0;
    end
  endtask

  task automatic readFlags();
    @(negedge clk) flagRead = 1'b1;
    @(negedge clk) flagRead = 1'b0;
  endtask

  task automatic setRate(logic [3:0] code);
    @(negedge clk) rateSel = code;
  endtask

  task automatic t_reset();
    check("R10 pf after reset", pfFlag, 1'b0);
    check("R10 irq after reset", irqReq, 1'b0);
  endtask

  task automatic t_basic();
    irqEnable = 1'b1;
    setRate(4'd3);
    tick(1);
    tick(3);
    check("R1 code3 before 4th", pfFlag, 1'b0);
    tick(1);
    check("R1 code3 at 4th", pfFlag, 1'b1);
    check("R4 irq with pf", irqReq, 1'b1);
    readFlags();
    check("R9 pf cleared", pfFlag, 1'b0);
    check("R9 irq cleared", irqReq, 1'b0);
    tick(3);
    check("R1 repeat before", pfFlag, 1'b0);
    tick(1);
    check("R1 repeat at period", pfFlag, 1'b1);
    readFlags();
    setRate(4'd6);
    tick(1);
    tick(31);
    check("R1 code6 before 32", pfFlag, 1'b0);
    tick(1);
    check("R1 code6 at 32", pfFlag, 1'b1);
    readFlags();
  endtask

  task automatic t_low();
    setRate(4'd1);
    tick(1);
    tick(127);
    check("R2 code1 before 128", pfFlag, 1'b0);
    tick(1);
    check("R2 code1 at 128", pfFlag, 1'b1);
    readFlags();
    setRate(4'd2);
    tick(1);
    tick(255);
    check("R2 code2 before 256", pfFlag, 1'b0);
    tick(1);
    check("R2 code2 at 256", pfFlag, 1'b1);
    readFlags();
  endtask

  task automatic t_noEnable();
    irqEnable = 1'b0;
    setRate(4'd4);
    tick(1);
    tick(8);
    check("R3 pf without enable", pfFlag, 1'b1);
    check("R3 no irq without enable", irqReq, 1'b0);
    readFlags();
    irqEnable = 1'b1;
  endtask

  task automatic t_hold();
    setRate(4'd3);
    tick(1);
    tick(2);
    @(negedge clk) divCtl = 3'b110;
    tick(10);
    check("R5 no event in hold", pfFlag, 1'b0);
    @(negedge clk) divCtl = 3'b010;
    tick(3);
    check("R5 restart from zero", pfFlag, 1'b0);
    tick(1);
    check("R5 full period after hold", pfFlag, 1'b1);
    readFlags();
  endtask

  task automatic t_freeze();
    tick(2);
    @(negedge clk) divCtl = 3'b011;
    tick(10);
    check("R6 no event frozen", pfFlag, 1'b0);
    @(negedge clk) divCtl = 3'b010;
    tick(1);
    check("R6 count kept, one left", pfFlag, 1'b0);
    tick(1);
    check("R6 event resumes", pfFlag, 1'b1);
    readFlags();
  endtask

  task automatic t_zero();
    setRate(4'd0);
    tick(300);
    check("R7 no event at code0", pfFlag, 1'b0);
    setRate(4'd3);
    tick(1);
    tick(3);
    check("R7 counter was zero", pfFlag, 1'b0);
    tick(1);
    check("R7 event after leaving code0", pfFlag, 1'b1);
    readFlags();
  endtask

  task automatic t_restart();
    tick(2);
    setRate(4'd4);
    tick(1);
    tick(7);
    check("R8 restart, no early event", pfFlag, 1'b0);
    tick(1);
    check("R8 event one new period later", pfFlag, 1'b1);
    readFlags();
  endtask

  task automatic t_collide();
    setRate(4'd3);
    tick(1);
    tick(3);
    @(negedge clk) begin tickEn = 1'b1; flagRead = 1'b1; end
    @(negedge clk) begin tickEn = 1'b0; flagRead = 1'b0; end
    check("R9 expiry wins pf", pfFlag, 1'b1);
    check("R9 expiry wins irq", irqReq, 1'b1);
    readFlags();
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_low();
    t_noEnable();
    t_hold();
    t_freeze();
    t_zero();
    t_restart();
    t_collide();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nVec++;
      nBad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nVec, nBad);
      $finish;
    end
  end
endmodule